// File: doc/BRIEF.md
# Configurable Three-Pin I/O Port with Chip-Select Outputs

This block is a small microcontroller-facing port of three pins. Each pin drives one of two values. The first is a bit of a CPU-writable output register. The second is an external chip-select term whose active level is set per pin. The enable of each pad also has two sources, chosen per pin: a bit of a CPU-writable direction register, or a separate output-enable term. The CPU reads the output register, the direction register or the synchronized live pin levels over a simple register interface.

Any pin can also be given a dedicated input role, and such a pin is always kept an input. Pin 0 acts as an address-latch strobe. Pin 1 acts as a clock input. Pin 2 acts as an active-low chip-select input: while that pin is high, a disable signal for the memories and the I/O decode is raised. Pad inputs pass through a two-flop synchronizer. The exception is the clock input, which is passed through raw.

Top module: `cfg_io_port`

## Requirements
- R1: After reset, the output register and the direction register are zero. With no enable term selected, every pad_oe bit is 0, and every pin driven from the register outputs 0.
- R2: A write with bus_addr=1 loads bus_wdata[2:0] into the output register at the clock edge. A read with bus_addr=1 returns it. A pin with cfg_out_sel=0 drives its register bit.
- R3: A write with bus_addr=2 loads the direction register, and a read with bus_addr=2 returns it. A non-dedicated pin with cfg_oe_sel=0 has pad_oe equal to its direction bit.
- R4: A pin with cfg_out_sel=1 drives its chip-select term cs_term when cfg_cs_pol=1 (active high), and drives the inverse of cs_term when cfg_cs_pol=0 (active low).
- R5: A non-dedicated pin with cfg_oe_sel=1 has pad_oe equal to its oe_term bit, whatever its direction bit holds.
- R6: A pin with cfg_dedic=1 has pad_oe=0, whatever its direction bit or enable term says.
- R7: A read with bus_addr=0 returns the pad_in levels after they pass two register stages. A change at the pads appears after the second rising edge and not after the first.
- R8: Read data bits 7:3 are always zero. Address 3 reads zero, and every read returns zero while bus_rd=0.
- R9: strobe_in equals the synchronized pad_in[0] when cfg_dedic[0]=1, and is 0 otherwise. clk_in follows pad_in[1] with no register when cfg_dedic[1]=1, and is 0 otherwise.
- R10: blk_disable is 1 only when cfg_dedic[2]=1 and the synchronized pad_in[2] is high.
- R11: Writes to address 0 or address 3 leave both the output register and the direction register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_out_sel | input | 3 | Per pin: 1 drives the chip-select term, 0 drives the output register |
| cfg_cs_pol | input | 3 | Per pin: 1 means the chip-select is active high, 0 means active low |
| cfg_oe_sel | input | 3 | Per pin: 1 takes the enable from oe_term, 0 from the direction bit |
| cfg_dedic | input | 3 | Per pin: 1 gives the pin its dedicated input role |
| cs_term | input | 3 | Chip-select product terms, one per pin |
| oe_term | input | 3 | Output-enable terms, one per pin |
| bus_addr | input | 2 | Register address: 0 pin levels, 1 output register, 2 direction register, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pad_in | input | 3 | Pad input levels |
| pad_out | output | 3 | Pad output values |
| pad_oe | output | 3 | Pad output enables |
| strobe_in | output | 1 | Address-latch strobe taken from pin 0 |
| clk_in | output | 1 | Clock taken from pin 1 |
| blk_disable | output | 1 | Memory and I/O decode disable taken from pin 2 |

## Verification
The bench builds the block with its default parameters: three pins, an eight-bit bus and two synchronizer stages. The three-pin width lets every combination of register-driven pins, chip-select-driven pins of either polarity, enable-term pins and dedicated pins appear together in one vector. The two-stage depth makes the one-edge versus two-edge latency of the pin-level read and of the strobe and disable outputs directly observable.

// File: rtl/cio_pkg.sv
package cio_pkg;
  typedef enum logic [1:0] {
    RA_DIN  = 2'd0,
    RA_DOUT = 2'd1,
    RA_DIR  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  // Level driven for a chip-select term: asserted term gives the active level
  function automatic logic cs_level(input logic term, input logic act_high);
    return act_high ? term : ~term;
  endfunction

  // Enable source choice, with the dedicated-input override
  function automatic logic oe_level(input logic dedic, input logic use_term,
                                    input logic term, input logic dir_bit);
    if (dedic) return 1'b0;
    return use_term ? term : dir_bit;
  endfunction
endpackage

// File: rtl/cio_sync.sv
module cio_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[k] <= '0;
      else        st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/cio_regs.sv
module cio_regs
  import cio_pkg::*;
#(
  parameter int NPINS = 3,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [DW-1:0]    bus_wdata,
  input  logic [NPINS-1:0] pin_lvl,
  output logic [DW-1:0]    bus_rdata,
  output logic [NPINS-1:0] dout_q,
  output logic [NPINS-1:0] dir_q
);
  reg_addr_e ra;
  logic      wr_dout, wr_dir, wr_ignored;

  assign ra         = reg_addr_e'(bus_addr);
  assign wr_dout    = bus_wr && (ra == RA_DOUT);
  assign wr_dir     = bus_wr && (ra == RA_DIR);
  assign wr_ignored = bus_wr && (ra == RA_DIN || ra == RA_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_dout) dout_q <= bus_wdata[NPINS-1:0];
      if (wr_dir)  dir_q  <= bus_wdata[NPINS-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (ra)
        RA_DIN:  bus_rdata[NPINS-1:0] = pin_lvl;
        RA_DOUT: bus_rdata[NPINS-1:0] = dout_q;
        RA_DIR:  bus_rdata[NPINS-1:0] = dir_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  // R2
  dout_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dout |=> dout_q == $past(bus_wdata[NPINS-1:0]));
  // R3
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(bus_wdata[NPINS-1:0]));
  // R11
  ignored_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored |=> $stable(dout_q) && $stable(dir_q));
endmodule

// File: rtl/cio_pin.sv
module cio_pin
  import cio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dout,
  input  logic dir,
  input  logic out_sel,
  input  logic pol,
  input  logic oe_sel,
  input  logic dedic,
  input  logic cs_t,
  input  logic oe_t,
  output logic pin_out,
  output logic pin_oe
);
  assign pin_out = out_sel ? cs_level(cs_t, pol) : dout;
  assign pin_oe  = oe_level(dedic, oe_sel, oe_t, dir);

  // R6
  dedic_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dedic |-> !pin_oe);
  // R2
  reg_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_sel |-> pin_out == dout);
  // R5
  term_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_sel && !dedic) |-> pin_oe == oe_t);
endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port #(
  parameter int NPINS       = 3,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] cfg_out_sel,
  input  logic [NPINS-1:0] cfg_cs_pol,
  input  logic [NPINS-1:0] cfg_oe_sel,
  input  logic [NPINS-1:0] cfg_dedic,
  input  logic [NPINS-1:0] cs_term,
  input  logic [NPINS-1:0] oe_term,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             strobe_in,
  output logic             clk_in,
  output logic             blk_disable
);
  localparam int PIN_STB = 0;
  localparam int PIN_CLK = 1;
  localparam int PIN_CSI = 2;

  logic [NPINS-1:0] pin_lvl;
  logic [NPINS-1:0] dout_q, dir_q;

  cio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_lvl)
  );

  cio_regs #(.NPINS(NPINS), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .pin_lvl(pin_lvl),
    .bus_rdata(bus_rdata), .dout_q(dout_q), .dir_q(dir_q)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    cio_pin u_pin (
      .clk(clk), .rst_n(rst_n), .dout(dout_q[i]), .dir(dir_q[i]),
      .out_sel(cfg_out_sel[i]), .pol(cfg_cs_pol[i]), .oe_sel(cfg_oe_sel[i]),
      .dedic(cfg_dedic[i]), .cs_t(cs_term[i]), .oe_t(oe_term[i]),
      .pin_out(pad_out[i]), .pin_oe(pad_oe[i])
    );
  end

  assign strobe_in   = cfg_dedic[PIN_STB] & pin_lvl[PIN_STB];
  assign clk_in      = cfg_dedic[PIN_CLK] & pad_in[PIN_CLK];
  assign blk_disable = cfg_dedic[PIN_CSI] & pin_lvl[PIN_CSI];

  // R8
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:NPINS] == '0);
  // R8
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);
  // R9
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dedic[PIN_STB] |-> !strobe_in);
  // R10
  disable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_disable |-> cfg_dedic[PIN_CSI] && !pad_oe[PIN_CSI]);
endmodule

// File: tb/cfg_io_port_test.sv
module cfg_io_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {out_sel, pol, oe_sel, dedic, cs, oe, dout, dir, exp_out, exp_oe}
  localparam logic [29:0] VEC [NV] = '{
    {3'b000,3'b000,3'b000,3'b000,3'b101,3'b000,3'b110,3'b011,3'b110,3'b011},
    {3'b111,3'b111,3'b000,3'b000,3'b101,3'b000,3'b000,3'b111,3'b101,3'b111},
    {3'b111,3'b000,3'b000,3'b000,3'b101,3'b000,3'b000,3'b111,3'b010,3'b111},
    {3'b101,3'b100,3'b111,3'b000,3'b011,3'b010,3'b010,3'b000,3'b010,3'b010},
    {3'b000,3'b000,3'b010,3'b101,3'b000,3'b111,3'b111,3'b111,3'b111,3'b010},
    {3'b010,3'b010,3'b001,3'b010,3'b010,3'b000,3'b100,3'b111,3'b110,3'b100}
  };

  logic clk = 0, rst_n = 0;
  logic [2:0] cfg_out_sel = 0, cfg_cs_pol = 0, cfg_oe_sel = 0, cfg_dedic = 0;
  logic [2:0] cs_term = 0, oe_term = 0, pad_in = 0;
  logic [1:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [2:0] pad_out, pad_oe;
  logic strobe_in, clk_in, blk_disable;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_io_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_out_sel(cfg_out_sel), .cfg_cs_pol(cfg_cs_pol),
    .cfg_oe_sel(cfg_oe_sel), .cfg_dedic(cfg_dedic), .cs_term(cs_term),
    .oe_term(oe_term), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .strobe_in(strobe_in),
    .clk_in(clk_in), .blk_disable(blk_disable)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  function automatic logic [7:0] rd(input logic [1:0] a);
    bus_addr = a; bus_rd = 1;
    return 8'h00;
  endfunction

  task automatic rdchk(input string req, input logic [1:0] a, input logic [7:0] exp);
    bus_addr = a; bus_rd = 1;
    #1;
    chk(req, bus_rdata, exp);
    bus_rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", {5'b0, pad_oe}, 8'h00);
    chk("R1 pad_out", {5'b0, pad_out}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    rdchk("R1 dout reg", 2'd1, 8'h00);
    rdchk("R1 dir reg", 2'd2, 8'h00);

    // Vector table: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      logic [29:0] t;
      t = VEC[v];
      wr(2'd1, {5'b0, t[11:9]});
      wr(2'd2, {5'b0, t[8:6]});
      cfg_out_sel = t[29:27]; cfg_cs_pol = t[26:24]; cfg_oe_sel = t[23:21];
      cfg_dedic = t[20:18]; cs_term = t[17:15]; oe_term = t[14:12];
      #1;
      chk("R2/R4 pad_out", {5'b0, pad_out}, {5'b0, t[5:3]});
      chk("R3/R5/R6 pad_oe", {5'b0, pad_oe}, {5'b0, t[2:0]});
      rdchk("R2 dout readback", 2'd1, {5'b0, t[11:9]});
      rdchk("R3 dir readback", 2'd2, {5'b0, t[8:6]});
    end
    cfg_out_sel = 0; cfg_cs_pol = 0; cfg_oe_sel = 0; cfg_dedic = 0;
    cs_term = 0; oe_term = 0;

    // R8 upper bits, unused address, idle read
    wr(2'd1, 8'hFF);
    rdchk("R8 upper bits", 2'd1, 8'h07);
    rdchk("R8 addr3", 2'd3, 8'h00);
    bus_addr = 2'd1; #1;
    chk("R8 no rd", bus_rdata, 8'h00);

    // R11 ignored writes
    wr(2'd2, 8'h05);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h00);
    rdchk("R11 dout kept", 2'd1, 8'h07);
    rdchk("R11 dir kept", 2'd2, 8'h05);

    // R7 synchronizer latency
    @(negedge clk);
    pad_in = 3'b101;
    @(negedge clk);
    rdchk("R7 one edge", 2'd0, 8'h00);
    @(negedge clk);
    rdchk("R7 two edges", 2'd0, 8'h05);

    // R9 strobe and raw clock
    chk("R9 strobe off", {7'b0, strobe_in}, 8'h00);
    cfg_dedic = 3'b011; #1;
    chk("R9 strobe on", {7'b0, strobe_in}, 8'h01);
    pad_in[1] = 1; #1;
    chk("R9 clk raw high", {7'b0, clk_in}, 8'h01);
    pad_in[1] = 0; #1;
    chk("R9 clk raw low", {7'b0, clk_in}, 8'h00);
    cfg_dedic = 3'b001; pad_in[1] = 1; #1;
    chk("R9 clk gated", {7'b0, clk_in}, 8'h00);

    // R10 chip-select input disable
    cfg_dedic = 3'b000; #1;
    chk("R10 not dedicated", {7'b0, blk_disable}, 8'h00);
    cfg_dedic = 3'b100; #1;
    chk("R10 pin high", {7'b0, blk_disable}, 8'h01);
    @(negedge clk);
    pad_in[2] = 0;
    @(negedge clk);
    chk("R10 one edge", {7'b0, blk_disable}, 8'h01);
    @(negedge clk);
    chk("R10 pin low", {7'b0, blk_disable}, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule